// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from one or more identical 4-bit slices. All state bits move together on the rising clock edge, so the count never passes through ripple states. The count can be preset from a parallel data bus, cleared to zero, held, or advanced by one. Counting needs two enables, a "parallel" enable P shared by every slice and a "trickle" enable T. T also gates the terminal-count carry, which makes cascading straightforward.

Inside the block, slice k takes its T from the carry of slice k-1, and slice 0 takes the external T. The wide count therefore advances as one synchronous binary counter, and the top-level carry goes high only when every bit is one and T is high. A parameter selects whether the active-low clear acts at once or at the next clock edge. An optional decode of a chosen last value drives the synchronous clear path, so the count returns to zero after that value rather than after all-ones.

Top module: `counter_chain`

## Requirements
- R1: When clear and load are both inactive at a rising edge and P and T are both high, the count increases by exactly one at that edge, with all bits updating together.
- R2: When clear and load are both inactive at a rising edge and P or T is low, the count keeps its value.
- R3: Load is active low and synchronous. When load is low at a rising edge and clear is inactive, the count takes the value on the data bus at that edge, whatever the levels of P and T.
- R4: With ASYNC_CLEAR=1, a low clear drives the count to zero at once, without waiting for a clock edge. The count stays zero while clear is low, whatever the levels of load, P and T.
- R5: With ASYNC_CLEAR=0, a low clear leaves the count unchanged until the next rising edge and sets it to zero at that edge. This clear wins over load and over the enables.
- R6: The carry output is high exactly when every count bit is one and T is high. A low T forces the carry low without a clock edge.
- R7: Counting from all-ones (for example 15 in a 4-bit slice, or 255 in the default 8-bit chain) gives zero.
- R8: In a chain, the upper slice advances by one only on the edge where every lower bit is one and counting is enabled. For example, 0x0F is followed by 0x10 in the default 8-bit chain.
- R9: With MOD_EN=1, an enabled count step from the value MOD_LAST, with load inactive, gives zero. The count sequence then has MOD_LAST+1 states.
- R10: In the default chain, clearing, presetting 12 and then counting gives 13, 14, 15, 0, 1, 2 in the low slice. Dropping P then holds 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clearN | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_CLEAR |
| loadN | input | 1 | Active-low synchronous parallel load |
| enP | input | 1 | Count enable shared by all slices |
| enT | input | 1 | Count enable fed into slice 0; also gates the carry |
| dataIn | input | STAGE_W*STAGES | Preset value |
| count | output | STAGE_W*STAGES | Current count |
| carryOut | output | 1 | High when the count is all ones and enT is high |

## Verification
The temporal properties assume that control inputs change away from the clock edge. They also assume that any clear pulse in the immediate-clear build stays low across at least one rising edge, so a clear that drops and releases between two edges never hides a step check. The stimulus changes every input on the falling edge, and it keeps the immediate clear low through the following rising edge. Two builds run side by side: the default immediate-clear 8-bit chain and a single 4-bit slice with the edge-timed clear and a decode that ends the count at 9. The edge-timed build is cleared from time zero, so its count is never unknown at a checked edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  // Strobes sent from a slice's control to its datapath; at most one is set.
  typedef struct packed {
    logic clr;   // force zero at the next edge
    logic ld;    // take parallel data at the next edge
    logic adv;   // add one at the next edge
  } ctrlStrobes_t;

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic         clearN,
  input  logic         wrapClr,
  input  logic         loadN,
  input  logic         enP,
  input  logic         enT,
  output ctrlStrobes_t strobes
);

  // Priority: clear, then load, then count.
  always_comb begin
    strobes.clr = !clearN || wrapClr;
    strobes.ld  = !strobes.clr && !loadN;
    strobes.adv = !strobes.clr && loadN && enP && enT;
  end

endmodule

// File: rtl/cnt_datapath.sv
module cnt_datapath
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] loadVal,
  input  logic         enT,
  output logic [W-1:0] value,
  output logic         carry
);

  localparam logic [W-1:0] TOP_VAL = '1;

  logic [W-1:0] nextVal;

  always_comb begin
    nextVal = value;
    if (strobes.clr)      nextVal = '0;
    else if (strobes.ld)  nextVal = loadVal;
    else if (strobes.adv) nextVal = value + W'(1);
  end

  // All bits of the slice share one edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) value <= '0;
    else       value <= nextVal;
  end

  // Terminal count, gated by the trickle enable.
  assign carry = (value == TOP_VAL) && enT;

endmodule

// File: rtl/counter_chain.sv
module counter_chain
  import cnt_pkg::*;
#(
  parameter int STAGE_W     = 4,
  parameter int STAGES      = 2,
  parameter bit ASYNC_CLEAR = 1'b1,
  parameter bit MOD_EN      = 1'b0,
  parameter int MOD_LAST    = 9
) (
  input  logic                      clk,
  input  logic                      clearN,
  input  logic                      loadN,
  input  logic                      enP,
  input  logic                      enT,
  input  logic [STAGE_W*STAGES-1:0] dataIn,
  output logic [STAGE_W*STAGES-1:0] count,
  output logic                      carryOut
);

  localparam int TOTAL_W = STAGE_W * STAGES;

  logic              regRstN;
  logic              wrapClr;
  logic [STAGES:0]   tChain;

  assign tChain[0] = enT;

  // Clear timing: wired to the register reset, or applied through the strobes only.
  generate
    if (ASYNC_CLEAR) begin : g_clrAsync
      assign regRstN = clearN;
    end else begin : g_clrSync
      assign regRstN = 1'b1;
    end
  endgenerate

  // Optional decode of the last value, feeding the edge-timed clear.
  generate
    if (MOD_EN) begin : g_modDecode
      assign wrapClr = (count == TOTAL_W'(MOD_LAST)) && enP && enT && loadN;
    end else begin : g_noDecode
      assign wrapClr = 1'b0;
    end
  endgenerate

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    ctrlStrobes_t strobes;

    cnt_ctrl u_ctrl (
      .clearN  (clearN),
      .wrapClr (wrapClr),
      .loadN   (loadN),
      .enP     (enP),
      .enT     (tChain[s]),
      .strobes (strobes)
    );

    cnt_datapath #(.W(STAGE_W)) u_dp (
      .clk     (clk),
      .rstN    (regRstN),
      .strobes (strobes),
      .loadVal (dataIn[s*STAGE_W +: STAGE_W]),
      .enT     (tChain[s]),
      .value   (count[s*STAGE_W +: STAGE_W]),
      .carry   (tChain[s+1])
    );
  end

  assign carryOut = tChain[STAGES];

endmodule

// File: rtl/counter_chain_chk.sv
module counter_chain_chk #(
  parameter int W           = 8,
  parameter bit ASYNC_CLEAR = 1'b1,
  parameter bit MOD_EN      = 1'b0,
  parameter int MOD_LAST    = 9
) (
  input logic         clk,
  input logic         clearN,
  input logic         loadN,
  input logic         enP,
  input logic         enT,
  input logic [W-1:0] dataIn,
  input logic [W-1:0] count,
  input logic         carryOut
);

  logic clrSeen = 1'b0;

  always_ff @(posedge clk) begin
    if (ASYNC_CLEAR && !clearN)
      AST_CLEAR_IMMEDIATE: assert (count == '0);  // R4
    if (!ASYNC_CLEAR && clrSeen)
      AST_CLEAR_AT_EDGE: assert (count == '0);    // R5
    clrSeen <= !clearN;
  end

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!clearN)
    !loadN |=> count == $past(dataIn));  // R3

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && !(enP && enT)) |=> $stable(count));  // R2

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && enP && enT && !(MOD_EN && count == W'(MOD_LAST)))
      |=> count == $past(count) + W'(1));  // R1

  AST_CARRY_NEEDS_T: assert property (@(posedge clk) disable iff (!clearN)
    !enT |-> !carryOut);  // R6

  AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (!clearN)
    (enT && (&count)) |-> carryOut);  // R6

  generate
    if (MOD_EN) begin : g_modChk
      AST_MOD_WRAP: assert property (@(posedge clk) disable iff (!clearN)
        (loadN && enP && enT && count == W'(MOD_LAST)) |=> count == '0);  // R9
    end
  endgenerate

endmodule

bind counter_chain counter_chain_chk #(
  .W           (TOTAL_W),
  .ASYNC_CLEAR (ASYNC_CLEAR),
  .MOD_EN      (MOD_EN),
  .MOD_LAST    (MOD_LAST)
) u_chk (
  .clk      (clk),
  .clearN   (clearN),
  .loadN    (loadN),
  .enP      (enP),
  .enT      (enT),
  .dataIn   (dataIn),
  .count    (count),
  .carryOut (carryOut)
);

// File: tb/counter_chain_tb.sv
module counter_chain_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // Unit A: default build (immediate clear, two slices)
  logic       aClearN, aLoadN, aEnP, aEnT, aCarry;
  logic [7:0] aData, aCount;
  // Unit B: edge-timed clear, one slice, ends after 9
  logic       bClearN, bLoadN, bEnP, bEnT, bCarry;
  logic [3:0] bData, bCount;

  counter_chain u_dut (
    .clk(clk), .clearN(aClearN), .loadN(aLoadN), .enP(aEnP), .enT(aEnT),
    .dataIn(aData), .count(aCount), .carryOut(aCarry)
  );

  counter_chain #(
    .STAGE_W(4), .STAGES(1), .ASYNC_CLEAR(1'b0), .MOD_EN(1'b1), .MOD_LAST(9)
  ) u_dut_sync (
    .clk(clk), .clearN(bClearN), .loadN(bLoadN), .enP(bEnP), .enT(bEnT),
    .dataIn(bData), .count(bCount), .carryOut(bCarry)
  );

  typedef struct {
    int         unitSel;
    logic [7:0] expCount;
    logic       expCarry;
    string      tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int errors = 0;

  task automatic compare(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cycA(logic clr, logic ld, logic p, logic t, logic [7:0] d,
                      logic [7:0] expC, logic expCy, string tag);
    @(negedge clk);
    aClearN = clr; aLoadN = ld; aEnP = p; aEnT = t; aData = d;
    sbq.push_back('{0, expC, expCy, tag});
  endtask

  task automatic cycB(logic clr, logic ld, logic p, logic t, logic [3:0] d,
                      logic [3:0] expC, logic expCy, string tag);
    @(negedge clk);
    bClearN = clr; bLoadN = ld; bEnP = p; bEnT = t; bData = d;
    sbq.push_back('{1, {4'h0, expC}, expCy, tag});
  endtask

  // Monitor: compares results just after each rising edge.
  always @(posedge clk) begin
    item_t it;
    #1;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      if (it.unitSel == 0) begin
        compare(it.tag, "count", aCount, it.expCount);
        compare(it.tag, "carry", {7'h0, aCarry}, {7'h0, it.expCarry});
      end else begin
        compare(it.tag, "count", {4'h0, bCount}, it.expCount);
        compare(it.tag, "carry", {7'h0, bCarry}, {7'h0, it.expCarry});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    aClearN = 1'b0; aLoadN = 1'b1; aEnP = 1'b0; aEnT = 1'b0; aData = '0;
    bClearN = 1'b0; bLoadN = 1'b1; bEnP = 1'b0; bEnT = 1'b0; bData = '0;
    repeat (2) @(negedge clk);
    compare("R4 reset", "count", aCount, 8'h00);
    compare("R5 reset", "count", {4'h0, bCount}, 8'h00);
    compare("R6 reset", "carry", {7'h0, aCarry}, 8'h00);

    // Unit A: reference sequence and cascade
    cycA(1, 1, 0, 0, 8'h00, 8'h00, 0, "R2 idle after clear");
    cycA(1, 0, 0, 0, 8'h0C, 8'h0C, 0, "R3 R10 preset 12");
    cycA(1, 1, 1, 1, 8'h00, 8'h0D, 0, "R10 count 13");
    cycA(1, 1, 1, 1, 8'h00, 8'h0E, 0, "R10 count 14");
    cycA(1, 1, 1, 1, 8'h00, 8'h0F, 0, "R10 count 15");
    cycA(1, 1, 1, 1, 8'h00, 8'h10, 0, "R8 R10 low slice 0, upper advances");
    cycA(1, 1, 1, 1, 8'h00, 8'h11, 0, "R10 count 1");
    cycA(1, 1, 1, 1, 8'h00, 8'h12, 0, "R1 R10 count 2");
    cycA(1, 1, 0, 1, 8'h00, 8'h12, 0, "R2 R10 inhibit holds 2");
    cycA(1, 1, 1, 0, 8'h00, 8'h12, 0, "R2 T low holds");
    cycA(1, 0, 1, 1, 8'hFE, 8'hFE, 0, "R3 load overrides enables");
    cycA(1, 1, 1, 1, 8'h00, 8'hFF, 1, "R6 carry at all ones with T");
    cycA(1, 1, 1, 0, 8'h00, 8'hFF, 0, "R6 T low gates carry");
    cycA(1, 1, 1, 1, 8'h00, 8'h00, 0, "R7 wrap to zero");
    cycA(1, 0, 0, 0, 8'h37, 8'h37, 0, "R3 load 0x37");
    @(negedge clk);
    aClearN = 1'b0; aLoadN = 1'b0; aData = 8'h99; aEnP = 1'b1; aEnT = 1'b1;
    #1 compare("R4 immediate clear", "count", aCount, 8'h00);
    cycA(0, 0, 1, 1, 8'h99, 8'h00, 0, "R4 clear holds over load");
    cycA(1, 1, 1, 1, 8'h00, 8'h01, 0, "R1 resumes after clear");
    cycA(1, 1, 0, 0, 8'h00, 8'h01, 0, "R2 idle");

    // Unit B: edge-timed clear and shortened modulus
    cycB(1, 0, 0, 0, 4'd5, 4'd5, 0, "R3 sync build load 5");
    cycB(0, 0, 1, 1, 4'd7, 4'd0, 0, "R5 clear beats load at edge");
    #1 compare("R5 no effect before edge", "count", {4'h0, bCount}, 8'h05);
    cycB(1, 0, 0, 0, 4'd8, 4'd8, 0, "R3 load 8");
    cycB(1, 1, 1, 1, 4'd0, 4'd9, 0, "R1 count 9");
    cycB(1, 1, 1, 1, 4'd0, 4'd0, 0, "R9 wrap after last value");
    cycB(1, 1, 1, 1, 4'd0, 4'd1, 0, "R9 continues from zero");
    cycB(1, 0, 1, 1, 4'd14, 4'd14, 0, "R3 load 14");
    cycB(1, 1, 1, 1, 4'd0, 4'd15, 1, "R6 R7 reaches 15 with carry");
    cycB(1, 1, 1, 1, 4'd0, 4'd0, 0, "R7 slice wraps 15 to 0");
    cycB(1, 1, 0, 1, 4'd0, 4'd0, 0, "R2 hold with P low");

    wait (sbq.size() == 0);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule